// File: doc/BRIEF.md
# Compare-Match System Timer

This block keeps a free-running 64-bit time base and a single compare channel, both reached through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. A divide-by-three prescaler sits in front of the counter, so the time base advances once for every three cycles of the input clock. Software reads the time base as two 32-bit words. It programs a compare value as a low word plus a 20-bit high word.

A control register arms the channel and can mask the interrupt. While the channel is armed and the time base is at or above the compare value, a sticky status flag sets and the interrupt output follows it, unless the mask suppresses it. Software acknowledges the event by disarming the channel, which clears the flag in the same write. The two counter words are not captured together. A consistent 64-bit value therefore needs the usual high, low, high read sequence, with a retry when the two high reads differ.

Top module: `sys_timer_cmp`

## Requirements
- R1: After reset the time base equals the parameter CNT_RESET (zero by default), the compare words and control bits read zero, and `irq_out` is low.
- R2: The time base increments by exactly one on every third rising clock edge after reset release, and holds its value on the other edges.
- R3: Reads of offset 0x8 return time base bits [31:0] and reads of 0xC return bits [63:32], live and uncaptured, so a carry from the low word into the high word shows between consecutive reads.
- R4: Compare low word (offset 0x10020, 32 bits) and compare high word (offset 0x10024) are read/write. Only bits [19:0] of the high word are stored, and bits [31:20] read as zero.
- R5: Control register at 0x1002C: bit 0 arms the channel, bit 1 masks the interrupt, bit 2 reads back the status flag, and the other bits read zero. Writes to bit 2 have no effect.
- R6: While armed, the status flag sets on the edge after the time base is greater than or equal to the 52-bit compare value {high[19:0], low}. It then stays set while the channel remains armed, even if the compare value moves.
- R7: A control write with bit 0 at zero clears the status flag, and `irq_out` is low from the following cycle.
- R8: `irq_out` is high exactly when the status flag is set and the mask bit is clear.
- R9: Reads of any other offset return zero. Writes to unmapped offsets and to the two counter words change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the prescaler divides it by three |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 17 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Compare interrupt, active high |

## Verification
On every cycle the assertions check the counter cadence: one increment on a prescaler tick, no change otherwise, and never two ticks in a row. They also check that a disarming write clears status and the interrupt on the next cycle, that the mask silences the output, that the flag exists only while the channel is armed, and that it stays sticky. The bench scenarios cover what needs absolute time or the register map. These are the counter value against elapsed cycles, the carry from the low word into the high word seen through the three-read sequence, the exact cycle at which a compare match raises the interrupt, truncation of the high compare word, and the register offsets that must read zero or ignore writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFS_CNT_LO  = 32'h0000_0008;
  localparam int unsigned OFS_CNT_HI  = 32'h0000_000C;
  localparam int unsigned OFS_CMP_LO  = 32'h0001_0020;
  localparam int unsigned OFS_CMP_HI  = 32'h0001_0024;
  localparam int unsigned OFS_CTRL    = 32'h0001_002C;
  localparam int unsigned CTRL_ARM    = 0;
  localparam int unsigned CTRL_MASK   = 1;
  localparam int unsigned CTRL_STATUS = 2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase_q, phase_d;

  always_comb begin
    tick    = (phase_q == LAST);
    phase_d = tick ? '0 : phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned     W       = 64,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int unsigned W       = 64,
  parameter int unsigned HI_BITS = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic               wr_ctrl,
  input  logic [31:0]        wdata,
  input  logic [W-1:0]       cnt,
  output logic [31:0]        cmp_lo,
  output logic [HI_BITS-1:0] cmp_hi,
  output logic               armed,
  output logic               masked,
  output logic               status
);
  localparam int unsigned PAD_W = W - 32 - HI_BITS;

  logic [31:0]        lo_q, lo_d;
  logic [HI_BITS-1:0] hi_q, hi_d;
  logic               arm_q, arm_d, msk_q, msk_d, st_q, st_d;
  logic [W-1:0]       cmp_full;
  logic               hit;

  always_comb begin
    cmp_full = {{PAD_W{1'b0}}, hi_q, lo_q};
    hit      = (cnt >= cmp_full);
    lo_d     = wr_lo ? wdata : lo_q;
    hi_d     = wr_hi ? wdata[HI_BITS-1:0] : hi_q;
    arm_d    = wr_ctrl ? wdata[tmr_pkg::CTRL_ARM]  : arm_q;
    msk_d    = wr_ctrl ? wdata[tmr_pkg::CTRL_MASK] : msk_q;
    st_d     = arm_d & (st_q | (arm_q & hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      arm_q <= 1'b0;
      msk_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      arm_q <= arm_d;
      msk_q <= msk_d;
      st_q  <= st_d;
    end
  end

  assign cmp_lo = lo_q;
  assign cmp_hi = hi_q;
  assign armed  = arm_q;
  assign masked = msk_q;
  assign status = st_q;
endmodule

// File: rtl/sys_timer_cmp.sv
module sys_timer_cmp #(
  parameter int unsigned  ADDR_W    = 17,
  parameter int unsigned  CNT_W     = 64,
  parameter int unsigned  DIV       = 3,
  parameter int unsigned  HI_BITS   = 20,
  parameter logic [63:0]  CNT_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFS_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFS_CNT_HI);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFS_CMP_LO);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFS_CMP_HI);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

  logic               tick;
  logic [CNT_W-1:0]   cnt_q;
  logic [31:0]        cmp_lo;
  logic [HI_BITS-1:0] cmp_hi;
  logic               en_q, mask_q, status_q;
  logic               wr_lo, wr_hi, wr_ctrl;

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  tmr_counter #(.W(CNT_W), .RST_VAL(CNT_W'(CNT_RESET))) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_q)
  );

  always_comb begin
    wr_lo   = bus_we && (bus_addr == A_CMP_LO);
    wr_hi   = bus_we && (bus_addr == A_CMP_HI);
    wr_ctrl = bus_we && (bus_addr == A_CTRL);
  end

  tmr_compare #(.W(CNT_W), .HI_BITS(HI_BITS)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctrl(wr_ctrl),
    .wdata(bus_wdata), .cnt(cnt_q),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .armed(en_q), .masked(mask_q), .status(status_q)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_q[31:0];
      A_CNT_HI: bus_rdata = cnt_q[63:32];
      A_CMP_LO: bus_rdata = cmp_lo;
      A_CMP_HI: bus_rdata = 32'(cmp_hi);
      A_CTRL: begin
        bus_rdata[CTRL_ARM]    = en_q;
        bus_rdata[CTRL_MASK]   = mask_q;
        bus_rdata[CTRL_STATUS] = status_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq_out = status_q & ~mask_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic              en,
  input logic              mask,
  input logic              status,
  input logic              irq_out,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata
);
  logic disarm_wr;
  assign disarm_wr = bus_we && (bus_addr == ADDR_W'(tmr_pkg::OFS_CTRL)) &&
                     !bus_wdata[tmr_pkg::CTRL_ARM];

  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + CNT_W'(1)));

  a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r7_disarm_ack: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_wr |=> (!status && !irq_out));

  a_r8_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq_out);

  a_r6_status_armed: assert property (@(posedge clk) disable iff (!rst_n)
    status |-> en);

  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !disarm_wr) |=> status);
endmodule

bind sys_timer_cmp tmr_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tmr_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_q),
  .en(en_q), .mask(mask_q), .status(status_q), .irq_out(irq_out),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/test_sys_timer_cmp.sv
module test_sys_timer_cmp;
  localparam logic [63:0] START = 64'h0000_0000_FFFF_FF40;

  logic        clk;
  logic        rst_n;
  logic [16:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  longint unsigned edges = 0;
  bit done = 0;

  sys_timer_cmp #(.CNT_RESET(START)) i_sys_timer_cmp (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  function automatic logic [63:0] exp_cnt();
    return START + 64'(edges / 3);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic expect_rd(input logic [16:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == e, req, 64'(v), 64'(e));
  endtask

  initial begin
    logic [31:0] v, h1, lo, h2;
    logic [63:0] e, cmpv;
    bit seen_carry;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    expect_rd(17'h0_0008, START[31:0], "R1");
    expect_rd(17'h0_000C, START[63:32], "R1");
    expect_rd(17'h1_0020, 32'h0, "R1");
    expect_rd(17'h1_0024, 32'h0, "R1");
    expect_rd(17'h1_002C, 32'h0, "R1");
    check(irq_out == 1'b0, "R1", 64'(irq_out), 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2: counter sweep against elapsed edges, every cycle for 30 cycles
    for (int i = 0; i < 30; i++) begin
      rd(17'h0_0008, v);
      e = exp_cnt();
      check(v == e[31:0], "R2", 64'(v), 64'(e[31:0]));
    end

    // R3: single reads straddling the low-to-high carry
    seen_carry = 0;
    for (int i = 0; i < 700 && !seen_carry; i++) begin
      rd(17'h0_000C, h1); e = exp_cnt();
      check(h1 == e[63:32], "R3", 64'(h1), 64'(e[63:32]));
      rd(17'h0_0008, lo); e = exp_cnt();
      check(lo == e[31:0], "R3", 64'(lo), 64'(e[31:0]));
      rd(17'h0_000C, h2);
      if (h1 != h2) seen_carry = 1;
    end
    check(seen_carry, "R3", 64'(seen_carry), 64'h1);
    // R3: high-low-high read with retry gives a consistent value
    do begin
      rd(17'h0_000C, h1); rd(17'h0_0008, lo); e = exp_cnt(); rd(17'h0_000C, h2);
    end while (h1 != h2);
    check({h1, lo} == e, "R3", {h1, lo}, e);

    // R4: compare registers and high-word truncation
    wr(17'h1_0020, 32'hA5A5_5A5A);
    expect_rd(17'h1_0020, 32'hA5A5_5A5A, "R4");
    wr(17'h1_0024, 32'hFFFF_FFFF);
    expect_rd(17'h1_0024, 32'h000F_FFFF, "R4");
    wr(17'h1_0024, 32'h1234_5678);
    expect_rd(17'h1_0024, 32'h0004_5678, "R4");

    // R9: unmapped reads, ignored writes
    expect_rd(17'h0_0004, 32'h0, "R9");
    expect_rd(17'h1_0028, 32'h0, "R9");
    expect_rd(17'h1_0030, 32'h0, "R9");
    wr(17'h1_0030, 32'hFFFF_FFFF);
    wr(17'h0_0008, 32'h0);
    wr(17'h0_000C, 32'hFFFF_FFFF);
    expect_rd(17'h1_0020, 32'hA5A5_5A5A, "R9");
    expect_rd(17'h1_0024, 32'h0004_5678, "R9");
    expect_rd(17'h1_002C, 32'h0, "R9");
    rd(17'h0_000C, v); e = exp_cnt();
    check(v == e[63:32], "R9", 64'(v), 64'(e[63:32]));

    // R6: armed with a far compare value never fires
    wr(17'h1_002C, 32'h1);
    repeat (20) @(negedge clk);
    check(irq_out == 1'b0, "R6", 64'(irq_out), 64'h0);
    wr(17'h1_002C, 32'h0);

    // R6/R8: match timing, checked every cycle
    e = exp_cnt();
    cmpv = e + 64'd8;
    wr(17'h1_0024, cmpv[63:32]);
    wr(17'h1_0020, cmpv[31:0]);
    wr(17'h1_002C, 32'h1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      // status at this point reflects counter value before the last edge
      e = START + 64'((edges - 1) / 3);
      check(irq_out == (e >= cmpv), "R6", 64'(irq_out), 64'(e >= cmpv));
    end
    // R6: sticky after compare moves far away
    wr(17'h1_0024, 32'h000F_FFFF);
    expect_rd(17'h1_002C, 32'h5, "R6");
    check(irq_out == 1'b1, "R6", 64'(irq_out), 64'h1);

    // R8: mask hides output but not status
    wr(17'h1_002C, 32'h3);
    check(irq_out == 1'b0, "R8", 64'(irq_out), 64'h0);
    expect_rd(17'h1_002C, 32'h7, "R8");
    wr(17'h1_002C, 32'h1);
    check(irq_out == 1'b1, "R8", 64'(irq_out), 64'h1);

    // R7: disarm acknowledges
    wr(17'h1_002C, 32'h0);
    check(irq_out == 1'b0, "R7", 64'(irq_out), 64'h0);
    expect_rd(17'h1_002C, 32'h0, "R7");

    // R5: writing bit 2 does not set status
    wr(17'h1_002C, 32'h4);
    expect_rd(17'h1_002C, 32'h0, "R5");
    check(irq_out == 1'b0, "R5", 64'(irq_out), 64'h0);
    wr(17'h1_002C, 32'h6);
    expect_rd(17'h1_002C, 32'h2, "R5");

    // R6: re-arm with compare already passed sets status next cycle
    wr(17'h1_0024, 32'h0);
    wr(17'h1_0020, 32'h0);
    wr(17'h1_002C, 32'h1);
    expect_rd(17'h1_002C, 32'h5, "R6");
    check(irq_out == 1'b1, "R6", 64'(irq_out), 64'h1);
    wr(17'h1_002C, 32'h0);
    check(irq_out == 1'b0, "R7", 64'(irq_out), 64'h0);

    // R2: final counter check
    rd(17'h0_0008, v); e = exp_cnt();
    check(v == e[31:0], "R2", 64'(v), 64'(e[31:0]));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule